// File: doc/BRIEF.md
# Shared RAM Host Access Port

This block sits between a host register bus and a memory owned by an attached coprocessor. The host cannot see that memory directly. Instead it loads a RAM pointer one byte at a time and then moves bytes through a single data register. When stepping is enabled, the pointer advances after every data access, so a whole block can be written, read back or compared with one address load.

The same block carries the control handshake between the two sides. One status/control byte holds run, stepping and pass-through enables for the coprocessor, plus a doorbell bit that the host rings to tell the coprocessor a mailbox has changed. The coprocessor clears the doorbell with an acknowledge input. Two flags raised by the coprocessor come back to the host through the same byte and are merged onto one interrupt line. The host reads the byte to tell the two flags apart and clears each one by writing a 1 to its bit.

Top module: `shram_host_port`

## Requirements
- R1: After reset the pointer is 0x0000, the control byte reads 0x00, and `host_irq`, `host_rvalid`, `cop_run`, `cop_bypass` and `cop_doorbell` are all low.
- R2: A write to offset 0 loads pointer bits 7:0 and a write to offset 1 loads pointer bits 15:8. Reading either offset returns that byte, and `ram_addr` always shows the full pointer.
- R3: A host write to offset 2 asserts `ram_we` in the same cycle, with `ram_addr` equal to the pointer and `ram_wdata` equal to the host byte.
- R4: A host read asserts `host_rvalid` exactly one cycle later. For offset 2, `host_rdata` then carries the RAM byte at the pointer that was current when the read was issued.
- R5: When control bit 1 (step) is set, every data-register access advances the pointer by one. When it is clear, the pointer does not change.
- R6: Stepping past 0xFFFF wraps the pointer to 0x0000.
- R7: Control bits 0 (pass-through), 1 (step) and 2 (run) read back as written. Bit 2 drives `cop_run` and bit 0 drives `cop_bypass`.
- R8: Writing 1 to control bit 3 sets `cop_doorbell`. Writing 0 to that bit leaves it unchanged. A `cop_doorbell_ack` pulse clears it, but a host set in the same cycle wins over the acknowledge.
- R9: `cop_int_set[0]` sets control bit 4 and `cop_int_set[1]` sets control bit 5. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R10: If a set pulse and a host clear reach the same flag in the same cycle, the flag ends up set.
- R11: `host_irq` is high exactly when at least one of control bits 4 and 5 is set.
- R12: Control bits 7:6 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register offset: 0 pointer low, 1 pointer high, 2 data, 3 control |
| host_wr | input | 1 | Write strobe, one cycle; takes priority over `host_rd` |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid while `host_rvalid` is high |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| host_irq | output | 1 | Merged coprocessor interrupt |
| ram_addr | output | 16 | RAM byte address (the pointer) |
| ram_wdata | output | 8 | RAM write byte |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable; the RAM returns data on the next cycle |
| ram_rdata | input | 8 | RAM read byte, one cycle after `ram_re` |
| cop_run | output | 1 | Coprocessor run enable |
| cop_bypass | output | 1 | Coprocessor pass-through mode |
| cop_doorbell | output | 1 | Mailbox doorbell to the coprocessor |
| cop_doorbell_ack | input | 1 | Coprocessor clears the doorbell |
| cop_int_set | input | 2 | Coprocessor pulses that set the two interrupt flags |

## Verification
The embedded assertions watch, on every cycle, several things: the pointer's one-step advance and its hold when idle, the one-cycle read-valid timing, set-over-clear priority on each flag, the doorbell's response to acknowledge, and that the interrupt line only rises after a set pulse. Some properties need stored RAM contents and host-visible values, so only the bench scenarios can show them. These are the byte-lane mapping of the two pointer registers, the readback layout of the control byte, the wrap at the top of the address space, the step-disabled case, and data read back correctly after a streamed write.

// File: rtl/shram_pkg.sv
package shram_pkg;
   // Control byte bit positions (host-visible layout)
   localparam int CTL_BYPASS   = 0;
   localparam int CTL_STEP     = 1;
   localparam int CTL_RUN      = 2;
   localparam int CTL_DOORBELL = 3;
   localparam int CTL_FLAG0    = 4;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_PTR  = 2'd1,
      SRC_CTL  = 2'd2
   } view_src_e;
endpackage

// File: rtl/shram_addr_ptr.sv
module shram_addr_ptr #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W/DATA_W-1:0]    lane_load,
   input  logic [DATA_W-1:0]           load_byte,
   input  logic                        step,
   output logic [ADDR_W-1:0]           ptr
);
   localparam int NLANES = ADDR_W / DATA_W;

   if ((ADDR_W % DATA_W) != 0) begin : g_bad_width
      $error("ADDR_W must be a multiple of DATA_W");
   end
   if (NLANES < 1) begin : g_bad_lanes
      $error("ADDR_W must be at least DATA_W");
   end

   logic [ADDR_W-1:0] ptr_stepped;
   assign ptr_stepped = step ? ptr + ADDR_W'(1) : ptr;

   for (genvar g = 0; g < NLANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            ptr[g*DATA_W +: DATA_W] <= '0;
         else if (lane_load[g])
            ptr[g*DATA_W +: DATA_W] <= load_byte;
         else
            ptr[g*DATA_W +: DATA_W] <= ptr_stepped[g*DATA_W +: DATA_W];
      end
   end

   // R5 / R6: a step moves the pointer by exactly one, modulo 2**ADDR_W
   assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && lane_load == '0) |=> ptr == $past(ptr) + ADDR_W'(1));

   // R5: no step and no load leaves the pointer alone
   assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && lane_load == '0) |=> $stable(ptr));
endmodule

// File: rtl/shram_ctl_reg.sv
module shram_ctl_reg
   import shram_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int NUM_INT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_byte,
   input  logic               bell_ack,
   input  logic [NUM_INT-1:0] flag_set,
   output logic               run,
   output logic               step_en,
   output logic               bypass,
   output logic               bell,
   output logic [NUM_INT-1:0] flags,
   output logic [DATA_W-1:0]  view
);
   if (CTL_FLAG0 + NUM_INT > DATA_W) begin : g_bad_flags
      $error("interrupt flags do not fit in the control byte");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run     <= 1'b0;
         step_en <= 1'b0;
         bypass  <= 1'b0;
      end else if (wr_en) begin
         run     <= wr_byte[CTL_RUN];
         step_en <= wr_byte[CTL_STEP];
         bypass  <= wr_byte[CTL_BYPASS];
      end
   end

   // Doorbell: host writes 1 to set, coprocessor acknowledge clears; host set wins
   logic bell_ring;
   assign bell_ring = wr_en && wr_byte[CTL_DOORBELL];

   always_ff @(posedge clk) begin
      if (!rst_n)         bell <= 1'b0;
      else if (bell_ring) bell <= 1'b1;
      else if (bell_ack)  bell <= 1'b0;
   end

   // Interrupt flags: coprocessor set has priority over host write-one-to-clear
   for (genvar g = 0; g < NUM_INT; g++) begin : g_flag
      logic host_clr;
      assign host_clr = wr_en && wr_byte[CTL_FLAG0 + g];

      always_ff @(posedge clk) begin
         if (!rst_n)           flags[g] <= 1'b0;
         else if (flag_set[g]) flags[g] <= 1'b1;
         else if (host_clr)    flags[g] <= 1'b0;
      end

      assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
         flag_set[g] |=> flags[g]);

      assert_flag_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (host_clr && !flag_set[g]) |=> !flags[g]);

      assert_flag_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[g] && !host_clr) |=> flags[g]);
   end

   always_comb begin
      view                 = '0;
      view[CTL_BYPASS]     = bypass;
      view[CTL_STEP]       = step_en;
      view[CTL_RUN]        = run;
      view[CTL_DOORBELL]   = bell;
      for (int i = 0; i < NUM_INT; i++) view[CTL_FLAG0 + i] = flags[i];
   end

   assert_bell_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bell_ack && !bell_ring) |=> !bell);

   assert_bell_win_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bell_ring |=> bell);

   assert_bell_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bell && !bell_ack) |=> bell);
endmodule

// File: rtl/shram_host_port.sv
module shram_host_port
   import shram_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int NUM_INT = 2,
   parameter int REG_AW  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [REG_AW-1:0]  host_addr,
   input  logic               host_wr,
   input  logic               host_rd,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   output logic               host_rvalid,
   output logic               host_irq,
   output logic [ADDR_W-1:0]  ram_addr,
   output logic [DATA_W-1:0]  ram_wdata,
   output logic               ram_we,
   output logic               ram_re,
   input  logic [DATA_W-1:0]  ram_rdata,
   output logic               cop_run,
   output logic               cop_bypass,
   output logic               cop_doorbell,
   input  logic               cop_doorbell_ack,
   input  logic [NUM_INT-1:0] cop_int_set
);
   localparam int NLANES  = ADDR_W / DATA_W;
   localparam int DATA_IX = NLANES;
   localparam int CTL_IX  = NLANES + 1;
   localparam logic [REG_AW-1:0] DATA_SEL = REG_AW'(DATA_IX);
   localparam logic [REG_AW-1:0] CTL_SEL  = REG_AW'(CTL_IX);

   if (CTL_IX >= (1 << REG_AW)) begin : g_bad_map
      $error("REG_AW too narrow for the register map");
   end

   // ---------------- decode ----------------
   logic rd_go, hit_data, hit_ctl, step;
   logic [NLANES-1:0] lane_load;
   logic [NLANES-1:0] lane_hit;

   assign rd_go    = host_rd && !host_wr;
   assign hit_data = (host_addr == DATA_SEL);
   assign hit_ctl  = (host_addr == CTL_SEL);

   for (genvar g = 0; g < NLANES; g++) begin : g_dec
      assign lane_hit[g]  = (host_addr == REG_AW'(g));
      assign lane_load[g] = host_wr && lane_hit[g];
   end

   // ---------------- sub-blocks ----------------
   logic [ADDR_W-1:0]  ptr;
   logic               step_en, bell;
   logic [NUM_INT-1:0] flags;
   logic [DATA_W-1:0]  ctl_view;

   shram_addr_ptr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane_load (lane_load),
      .load_byte (host_wdata),
      .step      (step),
      .ptr       (ptr)
   );

   shram_ctl_reg #(.DATA_W(DATA_W), .NUM_INT(NUM_INT)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (host_wr && hit_ctl),
      .wr_byte  (host_wdata),
      .bell_ack (cop_doorbell_ack),
      .flag_set (cop_int_set),
      .run      (cop_run),
      .step_en  (step_en),
      .bypass   (cop_bypass),
      .bell     (bell),
      .flags    (flags),
      .view     (ctl_view)
   );

   // ---------------- RAM port ----------------
   assign ram_addr  = ptr;
   assign ram_wdata = host_wdata;
   assign ram_we    = host_wr && hit_data;
   assign ram_re    = rd_go && hit_data;
   assign step      = step_en && (ram_we || ram_re);

   assign cop_doorbell = bell;
   assign host_irq     = |flags;

   // ---------------- read path ----------------
   view_src_e         src;
   logic [DATA_W-1:0] reg_view;

   always_comb begin
      src = SRC_NONE;
      if (hit_ctl)        src = SRC_CTL;
      else if (!hit_data) src = SRC_PTR;
   end

   always_comb begin
      reg_view = '0;
      case (src)
         SRC_CTL: reg_view = ctl_view;
         SRC_PTR: begin
            for (int i = 0; i < NLANES; i++)
               if (lane_hit[i]) reg_view = ptr[i*DATA_W +: DATA_W];
         end
         default: reg_view = '0;
      endcase
   end

   logic              rvalid_q, from_ram_q;
   logic [DATA_W-1:0] snap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q   <= 1'b0;
         from_ram_q <= 1'b0;
         snap_q     <= '0;
      end else begin
         rvalid_q <= rd_go;
         if (rd_go) begin
            from_ram_q <= hit_data;
            snap_q     <= reg_view;
         end
      end
   end

   assign host_rvalid = rvalid_q;
   assign host_rdata  = from_ram_q ? ram_rdata : snap_q;

   // R4: read valid appears exactly one cycle after an accepted read
   assert_rvalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go |=> host_rvalid);

   assert_rvalid_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_go |=> !host_rvalid);

   // R11: the merged line can only rise after a coprocessor set pulse
   assert_irq_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_irq) |-> $past(|cop_int_set));

   // R3: RAM is never read and written in the same cycle
   assert_ram_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && ram_re));
endmodule

// File: tb/test_shram_host_port.sv
module test_shram_host_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        host_rvalid, host_irq;
   logic [15:0] ram_addr;
   logic [7:0]  ram_wdata;
   logic        ram_we, ram_re;
   logic [7:0]  ram_rdata = '0;
   logic        cop_run, cop_bypass, cop_doorbell;
   logic        cop_doorbell_ack = 1'b0;
   logic [1:0]  cop_int_set = '0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   shram_host_port i_shram_host_port (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_rvalid(host_rvalid), .host_irq(host_irq), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
      .ram_rdata(ram_rdata), .cop_run(cop_run), .cop_bypass(cop_bypass),
      .cop_doorbell(cop_doorbell), .cop_doorbell_ack(cop_doorbell_ack),
      .cop_int_set(cop_int_set)
   );

   // RAM model: 256 bytes, indexed by the low address byte, one-cycle read
   logic [7:0] mem [256];
   always_ff @(posedge clk) begin
      if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
      if (ram_re) ram_rdata <= mem[ram_addr[7:0]];
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] off, input logic [7:0] val);
      @(negedge clk);
      host_addr = off; host_wdata = val; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] off, output logic [7:0] val, input string req);
      @(negedge clk);
      host_addr = off; host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      check(host_rvalid == 1'b1, req, host_rvalid, 1);
      val = host_rdata;
   endtask

   task automatic load_ptr(input logic [15:0] a);
      wr_reg(2'd0, a[7:0]);
      wr_reg(2'd1, a[15:8]);
   endtask

   task automatic read_ptr(output logic [15:0] a);
      logic [7:0] lo, hi;
      rd_reg(2'd0, lo, "R2");
      rd_reg(2'd1, hi, "R2");
      a = {hi, lo};
   endtask

   // R3: data write seen on the RAM port in the issuing cycle
   task automatic data_wr(input logic [7:0] val, input logic [15:0] exp_a);
      @(negedge clk);
      host_addr = 2'd2; host_wdata = val; host_wr = 1'b1;
      #1;
      check(ram_we && ram_addr == exp_a && ram_wdata == val, "R3",
            {ram_we, ram_addr, ram_wdata}, {1'b1, exp_a, val});
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   initial begin
      #1_000_000;
      errors++; checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0]  v;
      logic [15:0] a;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // ---- R1: reset state ----
      check(host_irq == 0 && host_rvalid == 0 && cop_run == 0 && cop_bypass == 0
            && cop_doorbell == 0, "R1", {host_irq, host_rvalid, cop_run, cop_bypass, cop_doorbell}, 0);
      check(ram_addr == 16'h0000, "R1", ram_addr, 0);
      rd_reg(2'd3, v, "R1");
      check(v == 8'h00, "R1", v, 0);

      // ---- R2: byte lane sweep of the pointer ----
      for (int i = 0; i < 16; i++) begin
         logic [15:0] t;
         t = 16'(i * 16'h1111) ^ 16'(i << 3);
         load_ptr(t);
         check(ram_addr == t, "R2", ram_addr, t);
         read_ptr(a);
         check(a == t, "R2", a, t);
      end

      // ---- R5/R3/R4: streamed write then read with stepping ----
      wr_reg(2'd3, 8'h02);
      load_ptr(16'h1240);
      for (int i = 0; i < 32; i++) data_wr(8'(i * 7 + 3), 16'h1240 + 16'(i));
      read_ptr(a);
      check(a == 16'h1260, "R5", a, 16'h1260);
      load_ptr(16'h1240);
      for (int i = 0; i < 32; i++) begin
         rd_reg(2'd2, v, "R4");
         check(v == 8'(i * 7 + 3), "R4", v, 8'(i * 7 + 3));
      end
      read_ptr(a);
      check(a == 16'h1260, "R5", a, 16'h1260);

      // ---- R5: stepping disabled keeps the pointer ----
      wr_reg(2'd3, 8'h00);
      load_ptr(16'h1310);
      data_wr(8'hA1, 16'h1310);
      data_wr(8'hB2, 16'h1310);
      rd_reg(2'd2, v, "R4");
      check(v == 8'hB2, "R5", v, 8'hB2);
      read_ptr(a);
      check(a == 16'h1310, "R5", a, 16'h1310);

      // ---- R6: wrap at top of address space ----
      wr_reg(2'd3, 8'h02);
      load_ptr(16'hFFFE);
      data_wr(8'h5C, 16'hFFFE);
      data_wr(8'h6D, 16'hFFFF);
      read_ptr(a);
      check(a == 16'h0000, "R6", a, 0);
      load_ptr(16'hFFFF);
      rd_reg(2'd2, v, "R6");
      check(v == 8'h6D, "R6", v, 8'h6D);
      read_ptr(a);
      check(a == 16'h0000, "R6", a, 0);

      // ---- R7/R12: enable bits sweep ----
      for (int m = 0; m < 8; m++) begin
         wr_reg(2'd3, 8'(m) | 8'hC0);
         rd_reg(2'd3, v, "R7");
         check(v == 8'(m), "R12", v, 8'(m));
         check(cop_run == m[2] && cop_bypass == m[0], "R7",
               {cop_run, cop_bypass}, {m[2], m[0]});
      end

      // ---- R8: doorbell ----
      wr_reg(2'd3, 8'h0C);
      check(cop_doorbell == 1, "R8", cop_doorbell, 1);
      wr_reg(2'd3, 8'h04);
      check(cop_doorbell == 1, "R8", cop_doorbell, 1);
      @(negedge clk); cop_doorbell_ack = 1'b1;
      @(negedge clk); cop_doorbell_ack = 1'b0;
      check(cop_doorbell == 0, "R8", cop_doorbell, 0);
      @(negedge clk);
      host_addr = 2'd3; host_wdata = 8'h0C; host_wr = 1'b1; cop_doorbell_ack = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; cop_doorbell_ack = 1'b0;
      check(cop_doorbell == 1, "R8", cop_doorbell, 1);
      @(negedge clk); cop_doorbell_ack = 1'b1;
      @(negedge clk); cop_doorbell_ack = 1'b0;

      // ---- R9/R11: flags, per bit ----
      for (int f = 0; f < 2; f++) begin
         @(negedge clk); cop_int_set = 2'(1 << f);
         @(negedge clk); cop_int_set = '0;
         check(host_irq == 1, "R11", host_irq, 1);
         rd_reg(2'd3, v, "R9");
         check(v == (8'h04 | 8'(16 << f)), "R9", v, 8'h04 | 8'(16 << f));
         wr_reg(2'd3, 8'h04);
         rd_reg(2'd3, v, "R9");
         check(v == (8'h04 | 8'(16 << f)), "R9", v, 8'h04 | 8'(16 << f));
         wr_reg(2'd3, 8'h04 | 8'(16 << f));
         rd_reg(2'd3, v, "R9");
         check(v == 8'h04, "R9", v, 8'h04);
         check(host_irq == 0, "R11", host_irq, 0);
      end

      // both flags, clear one at a time
      @(negedge clk); cop_int_set = 2'b11;
      @(negedge clk); cop_int_set = '0;
      wr_reg(2'd3, 8'h14);
      rd_reg(2'd3, v, "R9");
      check(v == 8'h24, "R9", v, 8'h24);
      check(host_irq == 1, "R11", host_irq, 1);
      wr_reg(2'd3, 8'h24);
      check(host_irq == 0, "R11", host_irq, 0);

      // ---- R10: set beats clear ----
      @(negedge clk);
      host_addr = 2'd3; host_wdata = 8'h34; host_wr = 1'b1; cop_int_set = 2'b01;
      @(negedge clk);
      host_wr = 1'b0; cop_int_set = '0;
      rd_reg(2'd3, v, "R10");
      check(v == 8'h14, "R10", v, 8'h14);
      check(host_irq == 1, "R10", host_irq, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule